// File: doc/BRIEF.md
# Systolic Linear Sorting Array

This block sorts a batch of 64-bit unsigned keys with a chain of identical compare-and-hold cells. Keys enter one per clock on a valid/ready stream. Each cell holds one key. When a key arrives, the cell keeps the smaller of the two and passes the larger to its neighbour on the next clock. All cells compare in the same cycle, so insertion is pipelined along the chain. When the batch is closed and no key is still moving, the chain shifts toward cell 0. The sorted keys then leave one per clock, smallest first.

Each output beat is tagged with one of two output buffers, so a consumer can read one buffer while the sorter fills the other. The sorter raises a per-buffer full flag when a batch has been written into that buffer, and the consumer clears the flag once it has read the buffer out. A batch holds at most `DEPTH` keys. Larger data sets are split by the producer into chunks of that size, and each chunk is sorted as an independent building block.

Top module: `systolic_sorter`

## Requirements
- R1: `in_ready` is high only while the sorter is loading. It is low in the first cycle after reset is released and high in the next cycle. It drops in the cycle after the `DEPTH`-th key or after a key marked `in_last` is accepted.
- R2: The output keys of a batch are the input keys of that batch, with no loss and no duplication, in ascending order by unsigned comparison of all 64 bits. Equal keys are all emitted.
- R3: A batch ended by `in_last` after m keys (1 <= m <= `DEPTH`) yields exactly m output beats. `out_last` is high on the m-th beat only.
- R4: For a full batch with `in_valid` held high, the last output beat occurs no more than 3*`DEPTH` cycles after the cycle of the first accepted key, provided the target buffer is free.
- R5: `out_buf` is 0 for the first batch after reset. It stays constant within a batch and flips for every following batch.
- R6: `buf_full[b]` becomes 1 in the cycle after the last beat written to buffer b. It is cleared by a one-cycle `buf_release[b]`. If the set and the release of the same buffer fall in the same cycle, the flag ends up set.
- R7: No output beat starts while the full flag of the buffer selected by `out_buf` is 1. Draining begins after that flag is released.
- R8: A synchronous reset discards any partially loaded keys, drives `out_valid` and `buf_full` to 0 and returns `out_buf` to 0.
- R9: A key presented with `in_valid` high while `in_ready` is low is not taken and does not appear in any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input key valid |
| in_ready | output | 1 | Sorter can take a key this cycle |
| in_key | input | 64 | Unsigned key |
| in_last | input | 1 | Marks the final key of a batch |
| out_valid | output | 1 | Output beat valid |
| out_key | output | 64 | Sorted key, ascending within a batch |
| out_last | output | 1 | Final beat of a batch |
| out_buf | output | 1 | Buffer that this beat is written to |
| buf_full | output | 2 | Per-buffer flag: a sorted batch is waiting to be read |
| buf_release | input | 2 | Consumer pulse that frees a buffer |

## Verification
The two buffer-flag actions can fall in the same cycle: the final drain beat sets the flag of the buffer being written, while the consumer pulses a release. The bench waits for the beat carrying `out_last` and raises the release of both buffers in that very cycle. The buffer just written must end up full and the other one empty. A second collision is between stalled draining and an input that keeps offering keys. With both buffers full, the bench holds `in_valid` high for 3*`DEPTH` cycles. It requires that no beat appears and that no offered key leaks into the sorted output after the release.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  parameter int unsigned KEY_BITS = 64;

  typedef logic [KEY_BITS-1:0] key_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_DRAIN
  } phase_e;

  // Ordering used by every cell: strict unsigned greater-than on the whole key.
  function automatic logic key_above(input key_t a, input key_t b);
    return a > b;
  endfunction

  // Buffer flag update: releases clear, the closing beat sets its buffer.
  function automatic logic [1:0] flag_next(input logic [1:0] cur,
                                           input logic [1:0] rel,
                                           input logic       set_en,
                                           input logic       set_idx);
    logic [1:0] nxt;
    nxt = cur & ~rel;
    if (set_en) nxt[set_idx] = 1'b1;
    return nxt;
  endfunction
endpackage

// File: rtl/sort_cell.sv
module sort_cell
  import sorter_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic ins_vld,
  input  key_t ins_key,
  input  logic up_vld,
  input  key_t up_key,
  output logic hold_vld,
  output key_t hold_key,
  output logic fwd_vld,
  output key_t fwd_key
);
  logic take_empty;
  logic swap_in;

  assign take_empty = ins_vld & ~hold_vld;
  assign swap_in    = ins_vld & hold_vld & key_above(hold_key, ins_key);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld <= 1'b0;
      hold_key <= '0;
      fwd_vld  <= 1'b0;
      fwd_key  <= '0;
    end else if (shift) begin
      hold_vld <= up_vld;
      hold_key <= up_key;
      fwd_vld  <= 1'b0;
    end else begin
      fwd_vld <= ins_vld & hold_vld;
      fwd_key <= swap_in ? hold_key : ins_key;
      if (take_empty || swap_in) hold_key <= ins_key;
      if (take_empty) hold_vld <= 1'b1;
    end
  end

  // R2: a key passed on is never below the one kept behind it
  a_r2_kept_not_above: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && fwd_vld) |-> !key_above(hold_key, fwd_key));

  // R2: an occupied cell stays occupied unless the chain shifts
  a_r2_no_loss: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && !shift) |=> hold_vld);
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_last,
  input  logic in_flight,
  input  logic tgt_full,
  output logic in_ready,
  output logic accept,
  output logic draining,
  output logic last_beat
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  phase_e            state;
  logic [CNT_W-1:0]  loaded;
  logic [CNT_W-1:0]  sent;

  assign in_ready  = (state == ST_LOAD);
  assign accept    = in_valid & in_ready;
  assign draining  = (state == ST_DRAIN);
  assign last_beat = draining && ((sent + 1'b1) == loaded);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      loaded <= '0;
      sent   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          loaded <= '0;
          sent   <= '0;
          state  <= ST_LOAD;
        end
        ST_LOAD: if (accept) begin
          loaded <= loaded + 1'b1;
          if (in_last || loaded == CNT_W'(DEPTH - 1)) state <= ST_SETTLE;
        end
        ST_SETTLE: if (!in_flight && !tgt_full) state <= ST_DRAIN;
        default: begin
          sent <= sent + 1'b1;
          if (last_beat) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R1: never more than DEPTH keys per batch
  a_r1_capacity: assert property (@(posedge clk) disable iff (rst)
    accept |-> (loaded < CNT_W'(DEPTH)));

  // R7: a full target buffer keeps the chain from draining
  a_r7_wait_for_buffer: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && tgt_full) |=> (state != ST_DRAIN));

  // R3: the closing beat is followed by a gap
  a_r3_single_last: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> !draining);
endmodule

// File: rtl/pingpong_sel.sv
module pingpong_sel
  import sorter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       batch_done,
  input  logic [1:0] release_req,
  output logic       sel,
  output logic [1:0] full,
  output logic       tgt_full
);
  assign tgt_full = full[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= 1'b0;
      full <= 2'b00;
    end else begin
      sel  <= sel ^ batch_done;
      full <= flag_next(full, release_req, batch_done, sel);
    end
  end

  // R6: the closing beat leaves its buffer marked full
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    batch_done |=> full[$past(sel)]);

  // R5: each finished batch moves to the other buffer
  a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
    batch_done |=> (sel != $past(sel)));
endmodule

// File: rtl/systolic_sorter.sv
module systolic_sorter
  import sorter_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [KEY_BITS-1:0] in_key,
  input  logic                in_last,
  output logic                out_valid,
  output logic [KEY_BITS-1:0] out_key,
  output logic                out_last,
  output logic                out_buf,
  output logic [1:0]          buf_full,
  input  logic [1:0]          buf_release
);
  // ch_*[i] feeds cell i; hv/hk[i] is what cell i holds, index DEPTH is the empty tail.
  logic ch_vld [DEPTH];
  key_t ch_key [DEPTH];
  logic hv     [DEPTH+1];
  key_t hk     [DEPTH+1];
  logic spill_vld;
  key_t spill_key;
  logic accept, draining, last_beat, in_flight, tgt_full;

  assign ch_vld[0]  = accept;
  assign ch_key[0]  = in_key;
  assign hv[DEPTH]  = 1'b0;
  assign hk[DEPTH]  = '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic fv;
    key_t fk;
    sort_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .shift    (draining),
      .ins_vld  (ch_vld[i]),
      .ins_key  (ch_key[i]),
      .up_vld   (hv[i+1]),
      .up_key   (hk[i+1]),
      .hold_vld (hv[i]),
      .hold_key (hk[i]),
      .fwd_vld  (fv),
      .fwd_key  (fk)
    );
    if (i < DEPTH - 1) begin : g_link
      assign ch_vld[i+1] = fv;
      assign ch_key[i+1] = fk;
    end else begin : g_tail
      assign spill_vld = fv;
      assign spill_key = fk;
    end
  end

  always_comb begin
    in_flight = spill_vld;
    for (int i = 1; i < DEPTH; i++) in_flight = in_flight | ch_vld[i];
  end

  sort_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_flight (in_flight),
    .tgt_full  (tgt_full),
    .in_ready  (in_ready),
    .accept    (accept),
    .draining  (draining),
    .last_beat (last_beat)
  );

  pingpong_sel u_bufsel (
    .clk         (clk),
    .rst         (rst),
    .batch_done  (last_beat),
    .release_req (buf_release),
    .sel         (out_buf),
    .full        (buf_full),
    .tgt_full    (tgt_full)
  );

  assign out_valid = draining;
  assign out_last  = last_beat;
  assign out_key   = hk[0];

  // R1: the chain never pushes a key past its last cell
  a_r1_no_spill: assert property (@(posedge clk) disable iff (rst)
    !spill_vld);

  // R2: anything leaving the tail would have to be above the tail's key
  a_r2_tail_order: assert property (@(posedge clk) disable iff (rst)
    spill_vld |-> !key_above(hk[DEPTH-1], spill_key));

  // R2: consecutive beats never step downward
  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> !key_above($past(out_key), out_key));

  // R3: every beat carries a real key
  a_r3_beat_has_key: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> hv[0]);
endmodule

// File: tb/tb_systolic_sorter.sv
module tb_systolic_sorter;
  import sorter_pkg::*;

  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_last, in_ready;
  key_t       in_key;
  logic       out_valid, out_last, out_buf;
  key_t       out_key;
  logic [1:0] buf_full, buf_release;

  always #10 clk = ~clk;

  systolic_sorter #(.DEPTH(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_last(in_last), .out_valid(out_valid),
    .out_key(out_key), .out_last(out_last), .out_buf(out_buf),
    .buf_full(buf_full), .buf_release(buf_release)
  );

  int   nchk = 0, nfail = 0, cyc = 0, beats = 0;
  int   first_cyc = 0, last_beat_cyc = 0;
  bit   done = 0;
  key_t kb [N];
  key_t exp_q [$];
  bit   exp_lq [$];
  key_t ek;
  bit   el;
  logic [1:0] model_full = 2'b00, nf;
  logic exp_buf = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference model: sorted queues and buffer flags, compared every clock mid-cycle.
  always begin
    @(negedge clk);
    #5;
    if (rst) begin
      model_full = 2'b00;
      exp_buf    = 1'b0;
      exp_q.delete();
      exp_lq.delete();
    end else begin
      check(buf_full == model_full, "R6 buffer flags", 64'(buf_full), 64'(model_full));
      check(!(in_ready && out_valid), "R1 ready while draining", 64'(in_ready), 64'd0);
      if (out_valid) begin
        beats++;
        if (exp_q.size() == 0) check(1'b0, "R3 beat with no key pending", out_key, 64'd0);
        else begin
          ek = exp_q.pop_front();
          el = exp_lq.pop_front();
          check(out_key == ek, "R2 sorted key", out_key, ek);
          check(out_last == el, "R3 last flag", 64'(out_last), 64'(el));
          check(out_buf == exp_buf, "R5 buffer select", 64'(out_buf), 64'(exp_buf));
        end
      end
      nf = model_full & ~buf_release;
      if (out_valid && out_last) begin
        nf[exp_buf]   = 1'b1;
        exp_buf       = ~exp_buf;
        last_beat_cyc = cyc;
      end
      model_full = nf;
    end
  end

  task automatic send_batch(input int m);
    key_t s [$];
    int   i = 0;
    while (i < m) begin
      @(negedge clk); #1;
      if (in_ready) begin
        in_valid = 1'b1;
        in_key   = kb[i];
        in_last  = (i == m - 1);
        if (i == 0) first_cyc = cyc + 1;
        i++;
      end else in_valid = 1'b0;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(in_ready == 1'b0, "R1 ready drops after batch end", 64'(in_ready), 64'd0);
    for (int k = 0; k < m; k++) s.push_back(kb[k]);
    s.sort();
    for (int k = 0; k < m; k++) begin
      exp_q.push_back(s[k]);
      exp_lq.push_back(k == m - 1);
    end
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic give_back(input logic [1:0] mask);
    @(negedge clk); #1 buf_release = mask;
    @(negedge clk); #1 buf_release = 2'b00;
  endtask

  task automatic fill_rand(input int m);
    for (int i = 0; i < m; i++) kb[i] = {$urandom(), $urandom()};
  endtask

  task automatic run_batch(input int m, input string tag);
    logic b;
    b = exp_buf;
    send_batch(m);
    wait_drained();
    if (m == N) check(last_beat_cyc - first_cyc <= 3 * N, {"R4 ", tag},
                      64'(last_beat_cyc - first_cyc), 64'(3 * N));
    give_back(2'b01 << b);
  endtask

  initial begin
    logic bs;
    int   seen;
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_key = '0; buf_release = 2'b00;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R8 reset ready", 64'(in_ready), 64'd0);
    check(out_valid == 1'b0, "R8 reset valid", 64'(out_valid), 64'd0);
    check(buf_full == 2'b00, "R8 reset flags", 64'(buf_full), 64'd0);
    check(out_buf == 1'b0, "R8 reset select", 64'(out_buf), 64'd0);
    rst = 1'b0;
    check(in_ready == 1'b0, "R1 first cycle after reset", 64'(in_ready), 64'd0);
    @(negedge clk); #1;
    check(in_ready == 1'b1, "R1 loading opens", 64'(in_ready), 64'd1);

    fill_rand(N);
    run_batch(N, "random full");
    for (int i = 0; i < N; i++) kb[i] = 64'hFFFF_0000_0000_0000 - 64'(i) * 64'h100;
    run_batch(N, "descending full");
    for (int i = 0; i < N; i++) kb[i] = 64'(i) << 40;
    run_batch(N, "ascending full");
    kb[0] = '1; kb[1] = '0; kb[2] = 64'h7; kb[3] = 64'h7; kb[4] = '0;
    run_batch(5, "R3 partial with extremes");
    kb[0] = 64'h8000_0000_0000_0001;
    run_batch(1, "R3 single key");
    for (int i = 0; i < 3; i++) kb[i] = 64'h1234_5678_9ABC_DEF0;
    run_batch(3, "R2 equal keys");

    // R6: release pulse lands in the same cycle as the closing beat
    bs = exp_buf;
    fill_rand(6);
    send_batch(6);
    while (!(out_valid && out_last)) @(negedge clk);
    #1 buf_release = 2'b11;
    @(negedge clk); #1 buf_release = 2'b00;
    @(negedge clk); #1;
    check(buf_full[bs] == 1'b1, "R6 set wins over release", 64'(buf_full), 64'(2'b01 << bs));
    check(buf_full[~bs] == 1'b0, "R6 other buffer freed", 64'(buf_full), 64'(2'b01 << bs));
    give_back(2'b01 << bs);

    // R7 and R9: both buffers full, the next batch waits while input keeps offering keys
    bs = exp_buf;
    fill_rand(4); send_batch(4); wait_drained();
    fill_rand(4); send_batch(4); wait_drained();
    check(buf_full == 2'b11, "R6 both buffers full", 64'(buf_full), 64'd3);
    fill_rand(N);
    send_batch(N);
    seen = beats;
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b1;
      in_key   = 64'h0;
      check(in_ready == 1'b0, "R9 no acceptance while stalled", 64'(in_ready), 64'd0);
    end
    check(beats == seen, "R7 no beat while target full", 64'(beats - seen), 64'd0);
    check(exp_q.size() == N, "R7 batch still held", 64'(exp_q.size()), 64'(N));
    in_valid = 1'b0;
    give_back(2'b01 << bs);
    wait_drained();
    give_back(2'b11);
    fill_rand(5);
    run_batch(5, "R9 batch after ignored input");

    // R8: reset in the middle of loading, with one buffer left full
    fill_rand(3); send_batch(3); wait_drained();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(in_ready == 1'b1, "R8 loading before reset", 64'(in_ready), 64'd1);
      in_valid = 1'b1;
      in_key   = 64'h0;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8 valid under reset", 64'(out_valid), 64'd0);
    check(buf_full == 2'b00, "R8 flags cleared", 64'(buf_full), 64'd0);
    check(out_buf == 1'b0, "R8 select cleared", 64'(out_buf), 64'd0);
    rst = 1'b0;
    fill_rand(N);
    for (int i = 0; i < N; i++) kb[i] = kb[i] | 64'h1;
    run_batch(N, "R8 clean batch after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule